// File: doc/BRIEF.md
# Wavelet Level Demultiplexer and Time Aligner

This block sits behind a single-array discrete wavelet transform engine. The engine emits all decomposition levels interleaved on one result line. The block splits that line into one detail (high-pass) line per level and one approximation line for the deepest level. It then delays every line so that sample 0 of every level leaves the block in the same cycle, which lets downstream analysis treat the levels as time-aligned. No word carries a level tag. The level is recovered from the fixed interleaving schedule, which repeats every 2^K slots: 1 2 1 3 1 2 1 4 and so on.

Each schedule slot carries a pair of words for one level: first the low-pass result, then the high-pass result. A two-state machine pairs the words. In ST_WANT_LO it waits for a low word, and a low word moves it to ST_WANT_HI. A high word in ST_WANT_LO is dropped and the state is kept. In ST_WANT_HI a further low word replaces the held one and the state is kept. A high word completes the slot and returns the machine to ST_WANT_LO.

A slot counter of K bits numbers the slots. The level of a slot is one plus the number of trailing zero bits of its number. A slot whose number is 0 modulo 2^K has no level in a K-level transform: its pair is consumed and discarded. Each level line is a delay line that advances once per completed slot, with `rst` a synchronous active-high reset.

Top module: `dwt_demux_align`

## Requirements
- R1: While `rst` is high at a clock edge, every `det_vld` bit and `apx_vld` are low after that edge. After reset, slot numbering restarts at 1, any held low word is discarded, and the machine is in ST_WANT_LO.
- R2: A word with `in_vld`=1 and `in_hi`=0 is a low word. A low word alone never produces an output pulse. Only a following word with `in_hi`=1 completes the slot.
- R3: A high word (`in_vld`=1, `in_hi`=1) that arrives while no low word is held is ignored. It advances no slot and produces no output.
- R4: A second low word that arrives before the high word replaces the held low word. Only the last one is used.
- R5: Slot s, counted from 1 after reset, belongs to level tz(s mod 2^K)+1, where tz counts trailing zero bits. A slot with s mod 2^K = 0 routes nothing to any line.
- R6: The high word of a level-i slot goes only to detail line i, which is `det_vld[i-1]` and `det_data[i*W-1 -: W]`. Low words of levels below K are discarded.
- R7: The low word of a level-K slot goes to the approximation line and appears in the same cycle as the level-K detail word.
- R8: A level-i word is delayed by 2^(K-1) - 2^(i-1) slots. Sample 0 of every level therefore appears in the same cycle, after slot 2^(K-1) completes. No output is valid before that slot. Whenever line K is valid, all detail lines are valid.
- R9: An output valid is a one-cycle pulse. It rises only in the cycle after a completing high word, so two output pulses are never in adjacent cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Result word present this cycle |
| in_hi | input | 1 | 1 = high-pass word, 0 = low-pass word |
| in_data | input | W | Result word |
| det_vld | output | LEVELS | Per-level detail valid, bit i-1 for level i |
| det_data | output | LEVELS*W | Per-level detail words, level i in bits i*W-1 down to (i-1)*W |
| apx_vld | output | 1 | Approximation valid (deepest level) |
| apx_data | output | W | Approximation word |

## Verification
The assertions watch properties that hold on every cycle:
- output pulses only follow a completing high word and never come back to back;
- the approximation never appears without the deepest detail;
- a deepest-level output always coincides with outputs on every shallower line;
- reset silences all lines.

Only the bench's scenarios can show that each word reaches the right line after exactly the right number of slots, with the right data. The same holds for the idle slot once per 2^K, the dropped stray high word, and the replaced low word. The bench shows these by comparing every line, after every slot, with values it computes from the slot number.

// File: rtl/dwt_demux_pkg.sv
package dwt_demux_pkg;

    // Pair-assembly states of the slot scheduler
    typedef enum logic {
        ST_WANT_LO = 1'b0,
        ST_WANT_HI = 1'b1
    } pair_state_t;

    // Level carried by a slot number: 1 + trailing zeros, 0 when idle
    function automatic int unsigned slot_level(input logic [7:0] num);
        int unsigned r;
        r = 0;
        for (int b = 7; b >= 0; b--) begin
            if (num[b]) r = b + 1;
        end
        return r;
    endfunction

    // Slots a level-lvl word waits so that sample 0 lines up with level 'levels'
    function automatic int lane_delay(input int levels, input int lvl);
        return (1 << (levels - 1)) - (1 << (lvl - 1));
    endfunction

endpackage

// File: rtl/dwt_slot_sched.sv
module dwt_slot_sched
    import dwt_demux_pkg::*;
#(
    parameter int LEVELS = 4,
    parameter int W      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic              in_hi,
    input  logic [W-1:0]      in_data,
    output logic              step_fire,
    output logic [LEVELS-1:0] step_lvl,
    output logic [W-1:0]      step_lo,
    output logic [W-1:0]      step_hi
);

    localparam int CW = LEVELS;

    pair_state_t   state_q;
    pair_state_t   state_d;
    logic          load_lo;
    logic [W-1:0]  lo_q;
    logic [CW-1:0] slot_q;
    int unsigned   cur_lvl;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_WANT_LO;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WANT_LO: if (in_vld && !in_hi) state_d = ST_WANT_HI;
            ST_WANT_HI: if (in_vld && in_hi)  state_d = ST_WANT_LO;
            default:    state_d = ST_WANT_LO;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        step_fire = 1'b0;
        load_lo   = 1'b0;
        unique case (state_q)
            ST_WANT_LO: load_lo = in_vld && !in_hi;
            ST_WANT_HI: begin
                load_lo   = in_vld && !in_hi;
                step_fire = in_vld && in_hi;
            end
            default: ;
        endcase
    end

    // Held low word and slot counter
    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q   <= '0;
            slot_q <= CW'(1);
        end else begin
            if (load_lo)   lo_q   <= in_data;
            if (step_fire) slot_q <= slot_q + CW'(1);
        end
    end

    assign cur_lvl = slot_level(8'(slot_q));
    assign step_lo = lo_q;
    assign step_hi = in_data;

    for (genvar j = 0; j < LEVELS; j++) begin : g_lvl
        assign step_lvl[j] = step_fire && (cur_lvl == (j + 1));
    end

endmodule

// File: rtl/dwt_lane_delay.sv
module dwt_lane_delay #(
    parameter int W     = 16,
    parameter int DEPTH = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift,
    input  logic         in_vld,
    input  logic [W-1:0] in_data,
    output logic         out_vld,
    output logic [W-1:0] out_data
);

    if (DEPTH == 0) begin : g_direct
        always_ff @(posedge clk) begin
            if (rst) begin
                out_vld  <= 1'b0;
                out_data <= '0;
            end else begin
                out_vld <= shift && in_vld;
                if (shift) out_data <= in_data;
            end
        end
    end else begin : g_chain
        logic [W-1:0]     st_d [DEPTH];
        logic [DEPTH-1:0] st_v;

        always_ff @(posedge clk) begin
            if (rst) begin
                st_v     <= '0;
                out_vld  <= 1'b0;
                out_data <= '0;
                for (int j = 0; j < DEPTH; j++) st_d[j] <= '0;
            end else begin
                out_vld <= 1'b0;
                if (shift) begin
                    st_v[0] <= in_vld;
                    st_d[0] <= in_data;
                    for (int j = 1; j < DEPTH; j++) begin
                        st_v[j] <= st_v[j-1];
                        st_d[j] <= st_d[j-1];
                    end
                    out_vld  <= st_v[DEPTH-1];
                    out_data <= st_d[DEPTH-1];
                end
            end
        end
    end

endmodule

// File: rtl/dwt_demux_align.sv
module dwt_demux_align
    import dwt_demux_pkg::*;
#(
    parameter int LEVELS = 4,   // 1 .. 8
    parameter int W      = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_vld,
    input  logic                in_hi,
    input  logic [W-1:0]        in_data,
    output logic [LEVELS-1:0]   det_vld,
    output logic [LEVELS*W-1:0] det_data,
    output logic                apx_vld,
    output logic [W-1:0]        apx_data
);

    logic              step_fire;
    logic [LEVELS-1:0] step_lvl;
    logic [W-1:0]      step_lo;
    logic [W-1:0]      step_hi;

    dwt_slot_sched #(.LEVELS(LEVELS), .W(W)) u_sched (
        .clk       (clk),
        .rst       (rst),
        .in_vld    (in_vld),
        .in_hi     (in_hi),
        .in_data   (in_data),
        .step_fire (step_fire),
        .step_lvl  (step_lvl),
        .step_lo   (step_lo),
        .step_hi   (step_hi)
    );

    // One detail lane per level, each with its own alignment depth
    for (genvar i = 0; i < LEVELS; i++) begin : g_det
        localparam int DLY = lane_delay(LEVELS, i + 1);
        dwt_lane_delay #(.W(W), .DEPTH(DLY)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .shift    (step_fire),
            .in_vld   (step_lvl[i]),
            .in_data  (step_hi),
            .out_vld  (det_vld[i]),
            .out_data (det_data[i*W +: W])
        );
    end

    // Deepest-level approximation needs no delay
    dwt_lane_delay #(.W(W), .DEPTH(0)) u_apx (
        .clk      (clk),
        .rst      (rst),
        .shift    (step_fire),
        .in_vld   (step_lvl[LEVELS-1]),
        .in_data  (step_lo),
        .out_vld  (apx_vld),
        .out_data (apx_data)
    );

endmodule

// File: rtl/dwt_demux_align_chk.sv
module dwt_demux_align_chk #(
    parameter int LEVELS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              in_vld,
    input logic              in_hi,
    input logic [LEVELS-1:0] det_vld,
    input logic              apx_vld
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (det_vld == '0 && !apx_vld)); // R1

    AST_PULSE_FROM_HI: assert property (@(posedge clk) disable iff (rst)
        (det_vld != '0 || apx_vld) |-> $past(in_vld && in_hi)); // R9

    AST_NO_ADJACENT: assert property (@(posedge clk) disable iff (rst)
        (det_vld != '0 || apx_vld) |=> (det_vld == '0 && !apx_vld)); // R9

    AST_APX_WITH_DEEP: assert property (@(posedge clk) disable iff (rst)
        apx_vld |-> det_vld[LEVELS-1]); // R7

    AST_DEEP_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        det_vld[LEVELS-1] |-> (&det_vld)); // R8

endmodule

bind dwt_demux_align dwt_demux_align_chk #(.LEVELS(LEVELS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .in_hi   (in_hi),
    .det_vld (det_vld),
    .apx_vld (apx_vld)
);

// File: tb/sim_dwt_demux_align.sv
module sim_dwt_demux_align;

    localparam int K          = 3;
    localparam int W          = 12;
    localparam int CLK_PERIOD = 10;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_vld = 1'b0;
    logic           in_hi = 1'b0;
    logic [W-1:0]   in_data = '0;
    logic [K-1:0]   det_vld;
    logic [K*W-1:0] det_data;
    logic           apx_vld;
    logic [W-1:0]   apx_data;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int s      = 0;

    dwt_demux_align #(.LEVELS(K), .W(W)) u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_hi(in_hi), .in_data(in_data),
        .det_vld(det_vld), .det_data(det_data), .apx_vld(apx_vld), .apx_data(apx_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [W-1:0] hi_word(input int n);
        return W'(n * 37 + 5);
    endfunction

    function automatic logic [W-1:0] lo_word(input int n);
        return W'(n * 53 + 11);
    endfunction

    // Level of slot n per R5; 0 for an idle slot
    function automatic int lvl_of(input int n);
        int m;
        int r;
        m = n % (1 << K);
        r = 0;
        if (m != 0) begin
            r = 1;
            while ((m % 2) == 0) begin
                m = m / 2;
                r = r + 1;
            end
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic vg, input logic ve,
                       input logic [W-1:0] dg, input logic [W-1:0] de);
        checks = checks + 1;
        if (vg !== ve || (ve && dg !== de)) begin
            errors = errors + 1;
            $display("FAIL %s slot %0d: got vld=%0b data=%h, expected vld=%0b data=%h",
                     tag, s, vg, dg, ve, de);
        end
    endtask

    task automatic chk_quiet(input string tag);
        chk(tag, (det_vld != '0) || apx_vld, 1'b0, '0, '0);
    endtask

    // Compare every line with the model after slot s completed (R5, R6, R7, R8)
    task automatic chk_lines(input string apx_tag);
        for (int i = 1; i <= K; i++) begin
            int t;
            logic ev;
            t  = s - ((1 << (K - 1)) - (1 << (i - 1)));
            ev = (t >= 1) && (lvl_of(t) == i);
            chk("R5/R6/R8", det_vld[i-1], ev, det_data[(i-1)*W +: W], hi_word(t));
        end
        chk(apx_tag, apx_vld, lvl_of(s) == K, apx_data, lo_word(s));
    endtask

    task automatic drive(input logic v, input logic h, input logic [W-1:0] d);
        in_vld  = v;
        in_hi   = h;
        in_data = d;
    endtask

    // One full slot: low word, high word, then check
    task automatic do_slot(input logic replace);
        s = s + 1;
        @(negedge clk);
        if (replace) begin
            drive(1'b1, 1'b0, 12'h5A5);
            @(negedge clk);
        end
        drive(1'b1, 1'b0, lo_word(s));
        @(negedge clk);
        chk_quiet("R2");
        drive(1'b1, 1'b1, hi_word(s));
        @(negedge clk);
        drive(1'b0, 1'b0, '0);
        chk_lines(replace ? "R4" : "R7");
        @(negedge clk);
        chk_quiet("R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_quiet("R1");
        rst = 1'b0;
        for (int n = 0; n < 41; n++) do_slot(1'b0);
        // stray high word with nothing held
        @(negedge clk);
        drive(1'b1, 1'b1, 12'hABC);
        @(negedge clk);
        drive(1'b0, 1'b0, '0);
        chk_quiet("R3");
        do_slot(1'b0);
        do_slot(1'b0);
        do_slot(1'b1);          // slot 44 is a deepest-level slot
        for (int n = 0; n < 16; n++) do_slot(1'b0);
        // reset with a low word held
        @(negedge clk);
        drive(1'b1, 1'b0, 12'h777);
        @(negedge clk);
        drive(1'b0, 1'b0, '0);
        rst = 1'b1;
        @(negedge clk);
        chk_quiet("R1");
        @(negedge clk);
        rst = 1'b0;
        s = 0;
        // a stray high word right after reset must be ignored too
        @(negedge clk);
        drive(1'b1, 1'b1, 12'h123);
        @(negedge clk);
        drive(1'b0, 1'b0, '0);
        chk_quiet("R1");
        for (int n = 0; n < 20; n++) do_slot(1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule